// File: doc/BRIEF.md
# Metering Power Mode Controller

This controller runs from the low-rate 32 kHz clock of an energy metering chip. It selects the chip's operating mode and drives the enables for the three converters: voltage, current and auxiliary. It also drives the converter sample rate, the converter bias level, the DSP function level and the enable of the global DSP clock gate. Software selects one of six modes with a one-cycle request: two full-function modes, one at full precision and one at reduced precision; a reduced-function mode; an anti-tamper mode that meters only current RMS; sleep; and a periodic current-detect mode.

In current-detect mode the chip dozes with everything stopped. After a programmable number of ticks it opens an observation window, during which only the current converter runs at the low rate. Each valid current sample's magnitude is compared against a trip level. A sample above the level moves the chip to anti-tamper mode at once. If the window closes quietly, the controller dozes again and the loop repeats.

The UART receive line doubles as a wake and reset input. A falling edge while dozing brings the chip back to the last run mode that software chose. Holding the line low for a fixed number of ticks forces full-function mode.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode is 0 (full function, full precision), all three converters are enabled at the high rate (`adc_rate_hi`=1) and high bias, `dsp_level` is 3 (all functions) and `dsp_clk_run` is 1.
- R2: A request with `mode_req_vld`=1 and a code from 0 to 5 sets `mode_out` to that code at the next clock edge. Codes 6 and 7 are ignored and the mode is kept. The codes are: 0 full/full, 1 full/reduced precision, 2 reduced function, 3 anti-tamper, 4 sleep, 5 current-detect.
- R3: Mode 1 keeps all converters and `dsp_level` 3 but drives the rate and bias low. Mode 2 turns the auxiliary converter off, keeps the high rate and bias, and uses `dsp_level` 2 (basic power and RMS). Both modes keep the DSP clock running.
- R4: Mode 3 enables only the current converter, at the low rate and low bias, with `dsp_level` 1 (current RMS only) and the DSP clock running.
- R5: In mode 4, and in mode 5 while dozing, every converter is off, `dsp_level` is 0 and `dsp_clk_run` is 0.
- R6: In mode 5 a window opens after `wake_period` ticks of dozing. During the window only the current converter is on, at the low rate and low bias, with the DSP clock still gated. The window lasts `watch_len` ticks (0 acts as 1). Dozing then resumes and the cycle repeats.
- R7: In mode 5 with `wake_period` equal to 0 no window ever opens.
- R8: During a window, a valid sample whose absolute value is strictly greater than `trip_level` sets the mode to 3 at the next edge. A magnitude equal to the level does not, and samples outside a window are ignored. The most negative code counts as magnitude 2^(SMP_W-1).
- R9: A falling edge on `rx_in` while in mode 4 or 5 restores the last requested mode in the range 0 to 3 (0 after reset), three edges after the line falls. In other modes a short low pulse has no effect.
- R10: `rx_in` held low for RST_HOLD synchronized ticks forces mode 0 and also makes 0 the mode restored by a later wake. Holding the line low longer causes no further event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_in | input | 1 | UART receive line, idle high, used for wake and reset |
| mode_req_vld | input | 1 | Mode request strobe |
| mode_req | input | 3 | Requested mode code |
| wake_period | input | PER_W | Doze ticks before each window, 0 disables |
| watch_len | input | WIN_W | Window length in ticks |
| trip_level | input | SMP_W | Unsigned magnitude threshold |
| cur_sample | input | SMP_W | Signed current sample |
| cur_sample_vld | input | 1 | Current sample valid |
| mode_out | output | 3 | Present mode code |
| adc_v_en | output | 1 | Voltage converter enable |
| adc_i_en | output | 1 | Current converter enable |
| adc_aux_en | output | 1 | Auxiliary converter enable |
| adc_rate_hi | output | 1 | 1 selects the high sample rate |
| adc_bias_hi | output | 1 | 1 selects the high converter bias |
| dsp_level | output | 2 | DSP function level 0 to 3 |
| dsp_clk_run | output | 1 | Global DSP clock gate enable |

## Verification
The hardest situation to reach from the ports is a trip inside the window of a later detect cycle, after one full window has already closed quietly. The stimulus counts the ticks of the first doze, the window and the second doze exactly. It places out-of-window samples above the level during the doze, and then drives a sample whose magnitude equals the level before one that exceeds it. The reset path is reached by holding the receive line low through a wake event and past the hold count. A later wake then shows that the restored mode was cleared.

// File: rtl/pmc_pkg.sv
// Shared types for the metering power mode controller.
// Assumes mode codes 0..5 are valid; 6 and 7 are unused.
package pmc_pkg;

    typedef enum logic [2:0] {
        MD_FULL   = 3'd0,
        MD_LOPREC = 3'd1,
        MD_LOFUNC = 3'd2,
        MD_TAMPER = 3'd3,
        MD_SLEEP  = 3'd4,
        MD_DETECT = 3'd5
    } pm_mode_e;

    typedef struct packed {
        logic       v_en;
        logic       i_en;
        logic       aux_en;
        logic       rate_hi;
        logic       bias_hi;
        logic [1:0] dsp_lvl;
        logic       clk_run;
    } pm_ctrl_t;

    localparam logic [1:0] DSP_OFF   = 2'd0;
    localparam logic [1:0] DSP_IRMS  = 2'd1;
    localparam logic [1:0] DSP_BASIC = 2'd2;
    localparam logic [1:0] DSP_ALL   = 2'd3;

    localparam logic [2:0] LAST_CODE = 3'd5;
    localparam logic [2:0] LAST_RUN  = 3'd3;

endpackage

// File: rtl/pmc_rx_monitor.sv
// Watches the UART receive line for wake and reset events.
// Assumes the line idles high; it is synchronized with two flops.
// wake_evt: one cycle on a synchronized falling edge.
// rst_evt: one cycle when the line has been low RST_HOLD ticks.
module pmc_rx_monitor #(
    parameter int RST_HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic wake_evt,
    output logic rst_evt
);
    localparam int HW = $clog2(RST_HOLD + 1);

    logic          sync1;
    logic          sync2;
    logic          prev;
    logic [HW-1:0] low_cnt;

    // Synchronize the line, remember its last value, count low ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1   <= 1'b1;
            sync2   <= 1'b1;
            prev    <= 1'b1;
            low_cnt <= '0;
        end else begin
            sync1 <= rx_in;
            sync2 <= sync1;
            prev  <= sync2;
            if (sync2)
                low_cnt <= '0;
            else if (low_cnt != HW'(RST_HOLD))
                low_cnt <= low_cnt + 1'b1;
        end
    end

    // Decode the one-cycle events.
    always_comb begin
        wake_evt = prev & ~sync2;
        rst_evt  = ~sync2 && (low_cnt == HW'(RST_HOLD - 1));
    end

endmodule

// File: rtl/pmc_detect_timer.sv
// Doze/window timer and magnitude comparator for current-detect mode.
// Assumes active is high only while the controller is in detect mode;
// when low the timer is held in its doze state with cleared counts.
module pmc_detect_timer #(
    parameter int PER_W = 16,
    parameter int WIN_W = 8,
    parameter int SMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active,
    input  logic [PER_W-1:0]        period,
    input  logic [WIN_W-1:0]        window,
    input  logic [SMP_W-1:0]        threshold,
    input  logic signed [SMP_W-1:0] sample,
    input  logic                    sample_vld,
    output logic                    watching,
    output logic                    hit
);
    logic             in_watch;
    logic [PER_W-1:0] doze_cnt;
    logic [WIN_W-1:0] win_cnt;
    logic             win_last;
    logic [SMP_W-1:0] raw;
    logic [SMP_W-1:0] mag;

    // Window ends on its last tick; zero length behaves as one tick.
    always_comb begin
        win_last = (window == '0) || (win_cnt == window - 1'b1);
    end

    // Alternate between dozing and watching.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            in_watch <= 1'b0;
            doze_cnt <= '0;
            win_cnt  <= '0;
        end else if (!in_watch) begin
            if (period != '0) begin
                if (doze_cnt == period - 1'b1) begin
                    in_watch <= 1'b1;
                    doze_cnt <= '0;
                end else begin
                    doze_cnt <= doze_cnt + 1'b1;
                end
            end
        end else begin
            if (win_last) begin
                in_watch <= 1'b0;
                win_cnt  <= '0;
            end else begin
                win_cnt <= win_cnt + 1'b1;
            end
        end
    end

    // Absolute value of the sample and the trip decision.
    always_comb begin
        raw      = sample;
        mag      = raw[SMP_W-1] ? (~raw + 1'b1) : raw;
        watching = active & in_watch;
        hit      = watching & sample_vld & (mag > threshold);
    end

endmodule

// File: rtl/pmc_ctrl_decode.sv
// Maps the present mode (and window state) to converter, DSP and gate
// controls. Purely combinational; assumes watching is only high in detect.
module pmc_ctrl_decode
    import pmc_pkg::*;
(
    input  pm_mode_e mode,
    input  logic     watching,
    output pm_ctrl_t ctrl
);
    // One control word per mode.
    always_comb begin
        ctrl = '0;
        case (mode)
            MD_FULL:   ctrl = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, DSP_ALL,   1'b1};
            MD_LOPREC: ctrl = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, DSP_ALL,   1'b1};
            MD_LOFUNC: ctrl = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, DSP_BASIC, 1'b1};
            MD_TAMPER: ctrl = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, DSP_IRMS,  1'b1};
            MD_DETECT: ctrl = watching ? '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, DSP_OFF, 1'b0}
                                       : '0;
            default:   ctrl = '0;
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Top of the metering power mode controller, clocked at 32 kHz.
// Chooses the operating mode from software requests, receive-line events
// and the current-detect trip, and drives the power controls.
// Priority: line reset, then wake (only while dozing), then request,
// then trip. Assumes the inputs are stable in the 32 kHz domain.
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int PER_W    = 16,
    parameter int WIN_W    = 8,
    parameter int SMP_W    = 16,
    parameter int RST_HOLD = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_in,
    input  logic                    mode_req_vld,
    input  logic [2:0]              mode_req,
    input  logic [PER_W-1:0]        wake_period,
    input  logic [WIN_W-1:0]        watch_len,
    input  logic [SMP_W-1:0]        trip_level,
    input  logic signed [SMP_W-1:0] cur_sample,
    input  logic                    cur_sample_vld,
    output logic [2:0]              mode_out,
    output logic                    adc_v_en,
    output logic                    adc_i_en,
    output logic                    adc_aux_en,
    output logic                    adc_rate_hi,
    output logic                    adc_bias_hi,
    output logic [1:0]              dsp_level,
    output logic                    dsp_clk_run
);
    pm_mode_e cur_mode;
    pm_mode_e run_mode;
    logic     wake_evt;
    logic     rst_evt;
    logic     watching;
    logic     hit;
    logic     dozing;
    logic     req_ok;
    pm_ctrl_t ctrl;

    pmc_rx_monitor #(.RST_HOLD(RST_HOLD)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_in    (rx_in),
        .wake_evt (wake_evt),
        .rst_evt  (rst_evt)
    );

    pmc_detect_timer #(.PER_W(PER_W), .WIN_W(WIN_W), .SMP_W(SMP_W)) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (cur_mode == MD_DETECT),
        .period     (wake_period),
        .window     (watch_len),
        .threshold  (trip_level),
        .sample     (cur_sample),
        .sample_vld (cur_sample_vld),
        .watching   (watching),
        .hit        (hit)
    );

    pmc_ctrl_decode u_dec (
        .mode     (cur_mode),
        .watching (watching),
        .ctrl     (ctrl)
    );

    // Qualify wake and request conditions.
    always_comb begin
        dozing = (cur_mode == MD_SLEEP) || (cur_mode == MD_DETECT);
        req_ok = mode_req_vld && (mode_req <= LAST_CODE);
    end

    // Mode state machine with the remembered run mode.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_evt) begin
            cur_mode <= MD_FULL;
            run_mode <= MD_FULL;
        end else if (wake_evt && dozing) begin
            cur_mode <= run_mode;
        end else if (req_ok) begin
            cur_mode <= pm_mode_e'(mode_req);
            if (mode_req <= LAST_RUN)
                run_mode <= pm_mode_e'(mode_req);
        end else if (hit) begin
            cur_mode <= MD_TAMPER;
        end
    end

    // Drive the ports from the decoded control word.
    always_comb begin
        mode_out    = cur_mode;
        adc_v_en    = ctrl.v_en;
        adc_i_en    = ctrl.i_en;
        adc_aux_en  = ctrl.aux_en;
        adc_rate_hi = ctrl.rate_hi;
        adc_bias_hi = ctrl.bias_hi;
        dsp_level   = ctrl.dsp_lvl;
        dsp_clk_run = ctrl.clk_run;
    end

endmodule

// File: rtl/pmc_checker.sv
// Assertions for the power mode controller, bound into pwr_mode_ctrl.
// Assumes the priority order line reset > wake > request > trip.
module pmc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       mode_req_vld,
    input logic [2:0] mode_req,
    input logic [2:0] mode_out,
    input logic       rst_evt,
    input logic       wake_evt,
    input logic       hit,
    input logic       adc_v_en,
    input logic       adc_i_en,
    input logic       dsp_clk_run
);
    logic dozing;
    always_comb dozing = (mode_out == 3'd4) || (mode_out == 3'd5);

    AST_REQ_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req_vld && mode_req <= 3'd5 && !rst_evt && !(wake_evt && dozing))
        |=> mode_out == $past(mode_req)); // R2

    AST_BAD_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_req_vld && mode_req > 3'd5 && !rst_evt && !(wake_evt && dozing) && !hit)
        |=> $stable(mode_out)); // R2

    AST_LINE_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_evt |=> mode_out == 3'd0); // R10

    AST_TRIP_TAMPER: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !rst_evt && !wake_evt && !mode_req_vld) |=> mode_out == 3'd3); // R8

    AST_TRIP_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (mode_out == 3'd5 && adc_i_en)); // R8

    AST_SLEEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_out == 3'd4) |-> (!dsp_clk_run && !adc_i_en && !adc_v_en)); // R5

    AST_CURRENT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_i_en && !adc_v_en) |-> (mode_out == 3'd3 || mode_out == 3'd5)); // R6

endmodule

bind pwr_mode_ctrl pmc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_req_vld (mode_req_vld),
    .mode_req     (mode_req),
    .mode_out     (mode_out),
    .rst_evt      (rst_evt),
    .wake_evt     (wake_evt),
    .hit          (hit),
    .adc_v_en     (adc_v_en),
    .adc_i_en     (adc_i_en),
    .dsp_clk_run  (dsp_clk_run)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
// Directed bench for the power mode controller; one task per scenario.
module tb_pwr_mode_ctrl;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               rx_in = 1'b1;
    logic               mode_req_vld = 1'b0;
    logic [2:0]         mode_req = 3'd0;
    logic [15:0]        wake_period = 16'd0;
    logic [7:0]         watch_len = 8'd0;
    logic [15:0]        trip_level = 16'd0;
    logic signed [15:0] cur_sample = 16'sd0;
    logic               cur_sample_vld = 1'b0;
    logic [2:0]         mode_out;
    logic               adc_v_en, adc_i_en, adc_aux_en, adc_rate_hi, adc_bias_hi;
    logic [1:0]         dsp_level;
    logic               dsp_clk_run;
    logic [7:0]         outs;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    // Control word: {v, i, aux, rate_hi, bias_hi, dsp[1:0], clk_run}
    localparam logic [7:0] W_FULL   = 8'hFF;
    localparam logic [7:0] W_LOPREC = 8'hE7;
    localparam logic [7:0] W_LOFUNC = 8'hDD;
    localparam logic [7:0] W_TAMPER = 8'h43;
    localparam logic [7:0] W_OFF    = 8'h00;
    localparam logic [7:0] W_WATCH  = 8'h40;

    always #2 clk = ~clk;

    assign outs = {adc_v_en, adc_i_en, adc_aux_en, adc_rate_hi, adc_bias_hi,
                   dsp_level, dsp_clk_run};

    pwr_mode_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in),
        .mode_req_vld(mode_req_vld), .mode_req(mode_req),
        .wake_period(wake_period), .watch_len(watch_len),
        .trip_level(trip_level), .cur_sample(cur_sample),
        .cur_sample_vld(cur_sample_vld), .mode_out(mode_out),
        .adc_v_en(adc_v_en), .adc_i_en(adc_i_en), .adc_aux_en(adc_aux_en),
        .adc_rate_hi(adc_rate_hi), .adc_bias_hi(adc_bias_hi),
        .dsp_level(dsp_level), .dsp_clk_run(dsp_clk_run)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic request(input logic [2:0] m);
        mode_req = m;
        mode_req_vld = 1'b1;
        tick();
        mode_req_vld = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        ticks(4);
        rst_n = 1'b1;
        tick();
        chk("R1 mode", mode_out, 3'd0);
        chk("R1 controls", outs, W_FULL);
    endtask

    task automatic t_requests();
        mode_req = 3'd1;
        mode_req_vld = 1'b1;
        chk("R2 before edge", mode_out, 3'd0);
        tick();
        mode_req_vld = 1'b0;
        chk("R2 mode 1", mode_out, 3'd1);
        chk("R3 reduced precision", outs, W_LOPREC);
        request(3'd2);
        chk("R3 reduced function", outs, W_LOFUNC);
        request(3'd7);
        chk("R2 code 7 ignored", mode_out, 3'd2);
        request(3'd6);
        chk("R2 code 6 ignored", outs, W_LOFUNC);
        request(3'd3);
        chk("R4 tamper mode", mode_out, 3'd3);
        chk("R4 tamper controls", outs, W_TAMPER);
        request(3'd4);
        chk("R5 sleep controls", outs, W_OFF);
        request(3'd0);
        chk("R2 back to full", outs, W_FULL);
    endtask

    task automatic t_wake();
        request(3'd1);
        rx_in = 1'b0;
        ticks(2);
        rx_in = 1'b1;
        ticks(6);
        chk("R9 no effect when running", mode_out, 3'd1);
        request(3'd4);
        rx_in = 1'b0;
        ticks(2);
        chk("R9 not yet awake", mode_out, 3'd4);
        rx_in = 1'b1;
        tick();
        chk("R9 woke to run mode", mode_out, 3'd1);
        ticks(4);
    endtask

    task automatic t_line_reset();
        request(3'd4);
        rx_in = 1'b0;
        ticks(3);
        chk("R9 wake before hold", mode_out, 3'd1);
        ticks(14);
        chk("R10 not yet reset", mode_out, 3'd1);
        tick();
        chk("R10 forced full", mode_out, 3'd0);
        request(3'd4);
        ticks(5);
        chk("R10 single event", mode_out, 3'd4);
        rx_in = 1'b1;
        ticks(4);
        rx_in = 1'b0;
        ticks(3);
        chk("R10 run mode cleared", mode_out, 3'd0);
        rx_in = 1'b1;
        ticks(4);
    endtask

    task automatic t_detect_cycle();
        wake_period = 16'd4;
        watch_len = 8'd3;
        trip_level = 16'd100;
        cur_sample = 16'sd50;
        cur_sample_vld = 1'b1;
        request(3'd5);
        chk("R5 detect dozing", outs, W_OFF);
        ticks(3);
        chk("R6 still dozing", outs, W_OFF);
        tick();
        chk("R6 window opens", outs, W_WATCH);
        ticks(2);
        chk("R6 window held", outs, W_WATCH);
        cur_sample = -16'sd50;
        tick();
        chk("R6 window closes", outs, W_OFF);
        cur_sample = 16'sd1000;
        ticks(2);
        chk("R8 sample outside window ignored", mode_out, 3'd5);
        cur_sample = 16'sd20;
        ticks(2);
        chk("R6 second window", outs, W_WATCH);
        cur_sample = -16'sd100;
        tick();
        chk("R8 equal magnitude no trip", mode_out, 3'd5);
        cur_sample = -16'sd101;
        tick();
        chk("R8 trip to tamper", mode_out, 3'd3);
        chk("R8 tamper controls", outs, W_TAMPER);
        cur_sample_vld = 1'b0;
    endtask

    task automatic t_short_window();
        wake_period = 16'd2;
        watch_len = 8'd0;
        trip_level = 16'h7FFF;
        cur_sample = 16'sd0;
        cur_sample_vld = 1'b1;
        request(3'd5);
        ticks(2);
        chk("R6 zero-length window open", outs, W_WATCH);
        tick();
        chk("R6 zero-length window one tick", outs, W_OFF);
        ticks(2);
        chk("R6 window repeats", outs, W_WATCH);
        cur_sample = 16'sh8000;
        tick();
        chk("R8 most negative trips", mode_out, 3'd3);
        cur_sample_vld = 1'b0;
    endtask

    task automatic t_period_zero();
        request(3'd2);
        wake_period = 16'd0;
        request(3'd5);
        ticks(20);
        chk("R7 no window", outs, W_OFF);
        chk("R7 stays detect", mode_out, 3'd5);
        rx_in = 1'b0;
        ticks(3);
        rx_in = 1'b1;
        chk("R9 wake from detect", mode_out, 3'd2);
        ticks(4);
    endtask

    initial begin
        t_reset();
        t_requests();
        t_wake();
        t_line_reset();
        t_detect_cycle();
        t_short_window();
        t_period_zero();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule